// File: doc/BRIEF.md
# Per-Pin Pin-Event Detector

This block watches a bank of already-synchronized pin levels and turns each pin's activity into a status flag and into interrupt, DMA-request or trigger signalling. Every pin has its own 4-bit condition code. The code picks what the pin reacts to and where the result goes:

- nothing at all;
- an edge that raises a DMA request;
- an edge that only sets the flag;
- a level or an edge that raises an interrupt;
- a trigger output that follows the pin, either straight or inverted.

Software reads the flags as a vector, with bit n belonging to pin n. It clears flags by writing ones through a clear strobe and mask. A DMA engine clears the flags of its own pins by pulsing a per-pin completion acknowledge. Edges are found by comparing each sample with the sample taken on the previous clock. The first cycle after reset reports no edge.

Top module: `evdet_top`

## Requirements
- R1: While reset is asserted, and right after it, every status flag, the interrupt line, every DMA request and every trigger output is 0.
- R2: Code 0x0 and the reserved codes 0x4 and 0xF never set the pin's flag and drive no request, interrupt or trigger.
- R3: Codes 0x1, 0x2 and 0x3 set the flag on a rising edge, a falling edge and either edge. The flag becomes visible on the clock edge that samples the new level. For these codes, `dma_req[n]` equals the flag.
- R4: A `dma_done[n]` pulse clears flag n when pin n uses code 0x1, 0x2 or 0x3. For any other code the pulse has no effect on the flag.
- R5: Codes 0x5, 0x6 and 0x7 set the flag on a rising edge, a falling edge and either edge. They raise neither an interrupt nor a DMA request.
- R6: Codes 0x9, 0xA and 0xB set the flag on a rising edge, a falling edge and either edge. Such a flag drives `irq_o`.
- R7: Code 0x8 sets the flag while the pin is 0, and code 0xC sets it while the pin is 1. If the level still holds when the flag is cleared, the flag reads 0 for one cycle and then reads 1 again.
- R8: With `sts_clr_we` high, each 1 in `sts_clr_mask` clears that flag and each 0 leaves it as it was. A clear beats a set event that arrives in the same cycle.
- R9: Code 0xD drives `trig_o[n]` to the pin level and code 0xE drives it to the inverted level, one clock after the sample. Neither code sets the flag.
- R10: Bit n of `sts_flag` belongs to pin n only. `irq_o` is the OR of the flags of the pins whose codes lie in 0x8 to 0xC.
- R11: No edge is seen on the first clock after reset is released, even if a pin is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Synchronized pin levels |
| pin_cond | input | 4*NUM_PINS | Condition code per pin; pin n in bits [4n+3:4n] |
| sts_clr_we | input | 1 | Clear strobe for the status flags |
| sts_clr_mask | input | NUM_PINS | Write-one-to-clear mask used with the strobe |
| dma_done | input | NUM_PINS | Per-pin DMA completion acknowledge |
| sts_flag | output | NUM_PINS | Status flags, bit n for pin n |
| irq_o | output | 1 | Combined interrupt |
| dma_req | output | NUM_PINS | Per-pin DMA request |
| trig_o | output | NUM_PINS | Per-pin trigger output |

## Verification
The flags and trigger outputs are registered. Each is due on the first rising edge that samples the stimulus. `dma_req` and `irq_o` are derived from the flags and appear together with them. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares every output against its own model on the next falling edge, so each result is read in exactly the cycle it is due. Clears, DMA acknowledges and level re-assertion are checked cycle by cycle in the same way: zero in the cycle after the clear, and one again a cycle later.

// File: rtl/evdet_pkg.sv
package evdet_pkg;

  parameter int unsigned EV_CODE_W = 4;

  typedef enum logic [EV_CODE_W-1:0] {
    EV_OFF      = 4'h0,
    EV_DMA_RISE = 4'h1,
    EV_DMA_FALL = 4'h2,
    EV_DMA_BOTH = 4'h3,
    EV_RSV_4    = 4'h4,
    EV_FLG_RISE = 4'h5,
    EV_FLG_FALL = 4'h6,
    EV_FLG_BOTH = 4'h7,
    EV_IRQ_LOW  = 4'h8,
    EV_IRQ_RISE = 4'h9,
    EV_IRQ_FALL = 4'hA,
    EV_IRQ_BOTH = 4'hB,
    EV_IRQ_HIGH = 4'hC,
    EV_TRIG_HI  = 4'hD,
    EV_TRIG_LO  = 4'hE,
    EV_RSV_F    = 4'hF
  } ev_code_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic to_dma;
    logic to_irq;
    logic trig_en;
    logic trig_inv;
  } ev_class_t;

  function automatic ev_class_t ev_classify(input logic [EV_CODE_W-1:0] code);
    ev_class_t c;
    c = '0;
    case (ev_code_e'(code))
      EV_DMA_RISE: begin c.on_rise = 1'b1; c.to_dma = 1'b1; end
      EV_DMA_FALL: begin c.on_fall = 1'b1; c.to_dma = 1'b1; end
      EV_DMA_BOTH: begin c.on_rise = 1'b1; c.on_fall = 1'b1; c.to_dma = 1'b1; end
      EV_FLG_RISE: c.on_rise = 1'b1;
      EV_FLG_FALL: c.on_fall = 1'b1;
      EV_FLG_BOTH: begin c.on_rise = 1'b1; c.on_fall = 1'b1; end
      EV_IRQ_LOW:  begin c.on_low = 1'b1; c.to_irq = 1'b1; end
      EV_IRQ_RISE: begin c.on_rise = 1'b1; c.to_irq = 1'b1; end
      EV_IRQ_FALL: begin c.on_fall = 1'b1; c.to_irq = 1'b1; end
      EV_IRQ_BOTH: begin c.on_rise = 1'b1; c.on_fall = 1'b1; c.to_irq = 1'b1; end
      EV_IRQ_HIGH: begin c.on_high = 1'b1; c.to_irq = 1'b1; end
      EV_TRIG_HI:  c.trig_en = 1'b1;
      EV_TRIG_LO:  begin c.trig_en = 1'b1; c.trig_inv = 1'b1; end
      default:     c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/evdet_decode.sv
module evdet_decode
  import evdet_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS*EV_CODE_W-1:0] pin_cond,
  output logic [NUM_PINS-1:0]           rise_en,
  output logic [NUM_PINS-1:0]           fall_en,
  output logic [NUM_PINS-1:0]           low_en,
  output logic [NUM_PINS-1:0]           high_en,
  output logic [NUM_PINS-1:0]           dma_en,
  output logic [NUM_PINS-1:0]           irq_en,
  output logic [NUM_PINS-1:0]           trig_en,
  output logic [NUM_PINS-1:0]           trig_inv
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    ev_class_t cls;
    assign cls         = ev_classify(pin_cond[g*EV_CODE_W +: EV_CODE_W]);
    assign rise_en[g]  = cls.on_rise;
    assign fall_en[g]  = cls.on_fall;
    assign low_en[g]   = cls.on_low;
    assign high_en[g]  = cls.on_high;
    assign dma_en[g]   = cls.to_dma;
    assign irq_en[g]   = cls.to_irq;
    assign trig_en[g]  = cls.trig_en;
    assign trig_inv[g] = cls.trig_inv;
  end

endmodule

// File: rtl/evdet_edge.sv
module evdet_edge #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  output logic [NUM_PINS-1:0] rise_det,
  output logic [NUM_PINS-1:0] fall_det
);

  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;
  logic                primed_en;

  always_comb begin
    primed_en = ~primed_q;
    rise_det  = {NUM_PINS{primed_q}} &  pin_lvl & ~prev_q;
    fall_det  = {NUM_PINS{primed_q}} & ~pin_lvl &  prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q <= pin_lvl;
      if (primed_en) primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/evdet_flags.sv
module evdet_flags #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] rise_det,
  input  logic [NUM_PINS-1:0] fall_det,
  input  logic [NUM_PINS-1:0] rise_en,
  input  logic [NUM_PINS-1:0] fall_en,
  input  logic [NUM_PINS-1:0] low_en,
  input  logic [NUM_PINS-1:0] high_en,
  input  logic [NUM_PINS-1:0] dma_en,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  input  logic [NUM_PINS-1:0] dma_done,
  output logic [NUM_PINS-1:0] flag_q
);

  logic [NUM_PINS-1:0] set_vec;
  logic [NUM_PINS-1:0] kill_vec;
  logic [NUM_PINS-1:0] flag_d;
  logic                flag_en;

  always_comb begin
    set_vec  = (rise_det & rise_en) | (fall_det & fall_en)
             | (~pin_lvl & low_en)  | (pin_lvl & high_en);
    kill_vec = ({NUM_PINS{clr_we}} & clr_mask) | (dma_done & dma_en);
    flag_d   = (flag_q | set_vec) & ~kill_vec;
    flag_en  = |(set_vec | kill_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/evdet_top.sv
module evdet_top
  import evdet_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_PINS-1:0]           pin_lvl,
  input  logic [NUM_PINS*EV_CODE_W-1:0] pin_cond,
  input  logic                          sts_clr_we,
  input  logic [NUM_PINS-1:0]           sts_clr_mask,
  input  logic [NUM_PINS-1:0]           dma_done,
  output logic [NUM_PINS-1:0]           sts_flag,
  output logic                          irq_o,
  output logic [NUM_PINS-1:0]           dma_req,
  output logic [NUM_PINS-1:0]           trig_o
);

  logic [NUM_PINS-1:0] rise_en, fall_en, low_en, high_en;
  logic [NUM_PINS-1:0] dma_en, irq_en, trig_en, trig_inv;
  logic [NUM_PINS-1:0] rise_det, fall_det;
  logic [NUM_PINS-1:0] trig_d, trig_q;

  evdet_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .pin_cond (pin_cond),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .low_en   (low_en),
    .high_en  (high_en),
    .dma_en   (dma_en),
    .irq_en   (irq_en),
    .trig_en  (trig_en),
    .trig_inv (trig_inv)
  );

  evdet_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .rise_det (rise_det),
    .fall_det (fall_det)
  );

  evdet_flags #(.NUM_PINS(NUM_PINS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .rise_det (rise_det),
    .fall_det (fall_det),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .low_en   (low_en),
    .high_en  (high_en),
    .dma_en   (dma_en),
    .clr_we   (sts_clr_we),
    .clr_mask (sts_clr_mask),
    .dma_done (dma_done),
    .flag_q   (sts_flag)
  );

  always_comb begin
    trig_d = trig_en & (pin_lvl ^ trig_inv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign trig_o  = trig_q;
  assign dma_req = sts_flag & dma_en;
  assign irq_o   = |(sts_flag & irq_en);

endmodule

// File: rtl/evdet_chk.sv
module evdet_chk
  import evdet_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_PINS*EV_CODE_W-1:0] pin_cond,
  input logic                          sts_clr_we,
  input logic [NUM_PINS-1:0]           sts_clr_mask,
  input logic [NUM_PINS-1:0]           dma_done,
  input logic [NUM_PINS-1:0]           sts_flag,
  input logic                          irq_o,
  input logic [NUM_PINS-1:0]           dma_req
);

  logic [NUM_PINS-1:0] is_dma_code;
  logic [NUM_PINS-1:0] can_set;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [EV_CODE_W-1:0] code;
    assign code           = pin_cond[g*EV_CODE_W +: EV_CODE_W];
    assign is_dma_code[g] = (code >= 4'h1) && (code <= 4'h3);
    assign can_set[g]     = (code != 4'h0) && (code != 4'h4) && (code < 4'hD);

    // R2 R9
    property p_flag_src;
      @(posedge clk) disable iff (!rst_n)
        $rose(sts_flag[g]) |-> $past(can_set[g]);
    endproperty
    flag_src_chk: assert property (p_flag_src);
  end

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_we |=> ((sts_flag & $past(sts_clr_mask)) == '0));

  // R4
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_done & is_dma_code)) |=> ((sts_flag & $past(dma_done & is_dma_code)) == '0));

  // R3
  dma_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_req & ~sts_flag) == '0));

  // R10
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|sts_flag));

endmodule

bind evdet_top evdet_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_cond     (pin_cond),
  .sts_clr_we   (sts_clr_we),
  .sts_clr_mask (sts_clr_mask),
  .dma_done     (dma_done),
  .sts_flag     (sts_flag),
  .irq_o        (irq_o),
  .dma_req      (dma_req)
);

// File: tb/evdet_top_bench.sv
module evdet_top_bench;

  localparam int NP = 32;

  logic            clk;
  logic            rst_n;
  logic [NP-1:0]   pin_lvl;
  logic [NP*4-1:0] pin_cond;
  logic            sts_clr_we;
  logic [NP-1:0]   sts_clr_mask;
  logic [NP-1:0]   dma_done;
  logic [NP-1:0]   sts_flag;
  logic            irq_o;
  logic [NP-1:0]   dma_req;
  logic [NP-1:0]   trig_o;

  evdet_top #(.NUM_PINS(NP)) u_evdet_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_lvl      (pin_lvl),
    .pin_cond     (pin_cond),
    .sts_clr_we   (sts_clr_we),
    .sts_clr_mask (sts_clr_mask),
    .dma_done     (dma_done),
    .sts_flag     (sts_flag),
    .irq_o        (irq_o),
    .dma_req      (dma_req),
    .trig_o       (trig_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  logic [NP-1:0] m_flag, m_prev, m_trig;
  bit            m_primed;

  function automatic logic [NP-1:0] mask_dma();
    logic [NP-1:0] m;
    for (int i = 0; i < NP; i++) begin
      int c;
      c = int'(pin_cond[i*4 +: 4]);
      m[i] = (c >= 1 && c <= 3);
    end
    return m;
  endfunction

  function automatic logic [NP-1:0] mask_irq();
    logic [NP-1:0] m;
    for (int i = 0; i < NP; i++) begin
      int c;
      c = int'(pin_cond[i*4 +: 4]);
      m[i] = (c >= 8 && c <= 12);
    end
    return m;
  endfunction

  function automatic string code_tag(int c);
    if (c >= 1 && c <= 3) return "R3";
    if (c >= 5 && c <= 7) return "R5";
    if (c == 8 || c == 12) return "R7";
    if (c >= 9 && c <= 11) return "R6";
    if (c == 13 || c == 14) return "R9";
    return "R2";
  endfunction

  task automatic cmp(string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  task automatic reset_model();
    m_flag = '0; m_prev = '0; m_trig = '0; m_primed = 1'b0;
  endtask

  task automatic set_all(int c);
    for (int i = 0; i < NP; i++) pin_cond[i*4 +: 4] = 4'(c);
  endtask

  // one clock: inputs already driven; compare outputs on the following falling edge
  task automatic step();
    logic [NP-1:0] nf, nt;
    for (int i = 0; i < NP; i++) begin
      int c;
      bit r, f, s, p, kill;
      c = int'(pin_cond[i*4 +: 4]);
      p = pin_lvl[i];
      r = m_primed && p && !m_prev[i];
      f = m_primed && !p && m_prev[i];
      s = 1'b0;
      if (c == 1 || c == 5 || c == 9)  s = r;
      if (c == 2 || c == 6 || c == 10) s = f;
      if (c == 3 || c == 7 || c == 11) s = r | f;
      if (c == 8)  s = !p;
      if (c == 12) s = p;
      kill = (sts_clr_we && sts_clr_mask[i]) || (dma_done[i] && c >= 1 && c <= 3);
      nf[i] = kill ? 1'b0 : (m_flag[i] | s);
      nt[i] = (c == 13) ? p : (c == 14) ? !p : 1'b0;
    end
    @(posedge clk);
    m_flag = nf; m_trig = nt; m_prev = pin_lvl; m_primed = 1'b1;
    @(negedge clk);
    cmp("status", sts_flag, m_flag);
    cmp("trigger", trig_o, m_trig);
    cmp("dma_req", dma_req, m_flag & mask_dma());
    cmp("irq", {31'b0, irq_o}, {31'b0, |(m_flag & mask_irq())});
  endtask

  task automatic clear_all();
    sts_clr_we = 1'b1; sts_clr_mask = '1; dma_done = '0;
    step();
    sts_clr_we = 1'b0; sts_clr_mask = '0;
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [NP-1:0] pats [8];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_A5A5; pats[3] = 32'h5A5A_5A5A;
    pats[4] = 32'h0000_0000; pats[5] = 32'h0000_FFFF;
    pats[6] = 32'h1234_5678; pats[7] = 32'hFFFF_FFFF;

    rst_n = 1'b0; pin_lvl = '1; set_all(9);
    sts_clr_we = 1'b0; sts_clr_mask = '0; dma_done = '0;
    reset_model();
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    cmp("status", sts_flag, '0);
    cmp("trigger", trig_o, '0);
    cmp("dma_req", dma_req, '0);
    cmp("irq", {31'b0, irq_o}, 32'b0);
    rst_n = 1'b1;

    // R11: pins already high when reset ends -> no rising edge
    cur_tag = "R11";
    repeat (3) step();

    // sweep every code on all pins
    for (int c = 0; c < 16; c++) begin
      cur_tag = code_tag(c);
      set_all(c);
      clear_all();
      for (int p = 0; p < 8; p++) begin
        pin_lvl = pats[p];
        dma_done = (c >= 1 && c <= 3 && p == 5) ? 32'h00FF_00FF : '0;
        step();
      end
      dma_done = '0;
      sts_clr_we = 1'b1; sts_clr_mask = 32'h0F0F_0F0F; step();
      sts_clr_mask = '0; step();
      sts_clr_we = 1'b0;
    end

    // R8: clear and rising edge in the same cycle; zero mask is a no-op
    cur_tag = "R8";
    set_all(9); pin_lvl = '0; clear_all();
    pin_lvl = '1; sts_clr_we = 1'b1; sts_clr_mask = '1; step();
    pin_lvl = '0; sts_clr_mask = '0; step();
    sts_clr_we = 1'b0; pin_lvl = '1; step();
    sts_clr_we = 1'b1; sts_clr_mask = '0; step();
    sts_clr_we = 1'b0;

    // R7: level re-assert after clear
    cur_tag = "R7";
    set_all(8); pin_lvl = '0; step();
    sts_clr_we = 1'b1; sts_clr_mask = '1; step();
    sts_clr_we = 1'b0; sts_clr_mask = '0; step();
    set_all(12); pin_lvl = 32'hFFFF_0000; step(); step();

    // R4: acknowledge clears DMA-coded flags, ignored on flag-only pins
    cur_tag = "R4";
    for (int i = 0; i < NP; i++) pin_cond[i*4 +: 4] = (i < 16) ? 4'h2 : 4'h6;
    pin_lvl = '1; clear_all();
    pin_lvl = '0; step();
    dma_done = '1; step();
    dma_done = '0; step();

    // R9: trigger outputs, straight on even pins, inverted on odd pins
    cur_tag = "R9";
    for (int i = 0; i < NP; i++) pin_cond[i*4 +: 4] = (i % 2 == 0) ? 4'hD : 4'hE;
    for (int p = 0; p < 8; p++) begin pin_lvl = pats[p]; step(); end

    // R10: mixed codes per pin, random stimulus
    cur_tag = "R10";
    for (int n = 0; n < 400; n++) begin
      if (n % 40 == 0)
        for (int i = 0; i < NP; i++) pin_cond[i*4 +: 4] = 4'($urandom_range(0, 15));
      pin_lvl      = $urandom;
      dma_done     = $urandom & $urandom & $urandom;
      sts_clr_we   = ($urandom_range(0, 7) == 0);
      sts_clr_mask = $urandom;
      step();
    end
    sts_clr_we = 1'b0; dma_done = '0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule